// File: doc/BRIEF.md
# Banked Memory Decoder with Write-Through

This block sits on a CPU bus and decides, for every bus cycle, which device responds. The devices are one port of a dual-port RAM that covers the whole address space, a set of overlay ROMs, an I/O block with a sound window inside it, and a character ROM that shares the I/O address range. Three bank-control inputs shape the map. The first is a per-ROM mapped-in vector. The second is an I/O-visible flag. The third is a character-ROM-visible flag, which takes effect only while I/O is hidden.

Reads from a mapped overlay are served by the ROM, and the RAM underneath stays off the bus. Writes to the same addresses fall through to that RAM. The I/O block is different when visible: it claims both reads and writes, and the RAM under it is hidden. The character ROM answers reads only, so writes in its range still reach RAM.

RAM enable is split in two. The decode result drives `ram_ce0_n` (active low). `ram_ce1` (active high) follows the phase-2 clock. Output-enable, write-enable and every device select are additionally gated by phase-2, so nothing drives the data bus while the address is settling.

All outputs are registered on `clk` and reflect the inputs sampled at the previous rising edge. `phi2` is treated as a level input sampled by `clk`.

Top module: `mem_decoder`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the outputs take these values after that edge: `ram_ce0_n`=1, `ram_ce1`=0, `ram_oe_n`=1, `ram_we_n`=1, and all selects 0.
- R2: Every output reflects the inputs sampled at the previous rising edge of `clk` (one cycle of latency). `ram_ce1` equals the sampled `phi2`. While the sampled `phi2` is 0, `ram_oe_n` and `ram_we_n` are 1 and every select is 0, although `ram_ce0_n` still shows the decode result.
- R3: A read (`cpu_rw`=1) inside overlay region i while `rom_map[i]`=1 and `phi2`=1 gives `rom_sel[i]`=1, `ram_ce0_n`=1 and `ram_oe_n`=1. Defaults: region 0 is 0xA000–0xBFFF and region 1 is 0xE000–0xFFFF. If regions overlap, the lowest index wins.
- R4: A write (`cpu_rw`=0) inside an overlay region gives `ram_ce0_n`=0 and `ram_we_n`=0 whatever `rom_map` holds, with no `rom_sel` bit set.
- R5: A read inside overlay region i while `rom_map[i]`=0 is served by RAM: `ram_ce0_n`=0 and `ram_oe_n`=0.
- R6: With `io_map`=1, reads and writes in the I/O block (default 0xD000–0xDFFF) select an I/O device. `ram_ce0_n`, `ram_oe_n` and `ram_we_n` all stay 1.
- R7: Inside the I/O block, addresses in the sound window (default 0xD400–0xD7FF) assert `snd_sel`. The rest of the block asserts `io_sel`.
- R8: With `io_map`=0 and `chr_map`=1, a read in the I/O block asserts `chr_sel` with RAM off the bus. A write there goes to RAM (`ram_we_n`=0).
- R9: With `io_map`=1, `chr_sel` is never asserted.
- R10: With `io_map`=0 and `chr_map`=0, the I/O block range is ordinary RAM for reads and writes.
- R11: At most one of `rom_sel` bits, `io_sel`, `snd_sel`, `chr_sel` and a low `ram_oe_n` is active at once. `ram_oe_n` and `ram_we_n` are never low together.
- R12: Addresses outside every overlay and the I/O block go to RAM for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 level, high during data transfer |
| rom_map | input | NUM_ROM | Per-overlay mapped-in flag |
| io_map | input | 1 | I/O block visible |
| chr_map | input | 1 | Character ROM visible when I/O is hidden |
| ram_ce0_n | output | 1 | RAM enable from decode, active low |
| ram_ce1 | output | 1 | RAM enable following phase-2, active high |
| ram_oe_n | output | 1 | RAM output-enable, active low |
| ram_we_n | output | 1 | RAM write-enable, active low |
| rom_sel | output | NUM_ROM | Overlay ROM selects, active high |
| io_sel | output | 1 | General I/O select |
| snd_sel | output | 1 | Sound window select |
| chr_sel | output | 1 | Character ROM select |

## Verification
A wrong routing decision shows at the ports one clock after the offending inputs are sampled, as two responders at once or as none. Examples are a ROM read that also drops `ram_oe_n`, a write under an overlay that never lowers `ram_we_n`, or a character-ROM select while I/O is visible. Each of these is visible in the very next sampled cycle. Because there is no state beyond the output registers, an error cannot hide and surface later. The bench therefore checks each scenario in the cycle right after its inputs are applied, with phase-2 both low and high.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [2:0] {
    TGT_RAM = 3'd0,
    TGT_ROM = 3'd1,
    TGT_IO  = 3'd2,
    TGT_SND = 3'd3,
    TGT_CHR = 3'd4
  } tgt_e;

endpackage

// File: rtl/mdec_region.sv
module mdec_region #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // SIZE is a power of two and BASE is aligned to it
  localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] MASK = ~(SIZE - ONE);

  assign hit = ((addr & MASK) == (BASE & MASK));
endmodule

// File: rtl/mdec_route.sv
module mdec_route
  import mdec_pkg::*;
#(
  parameter int unsigned NUM_ROM = 2
) (
  input  logic               rw,
  input  logic               in_io,
  input  logic               in_snd,
  input  logic [NUM_ROM-1:0] rom_hit,
  input  logic [NUM_ROM-1:0] rom_map,
  input  logic               io_map,
  input  logic               chr_map,
  output tgt_e               tgt,
  output logic [NUM_ROM-1:0] rom_oh
);
  logic [NUM_ROM-1:0] rom_live;
  logic               rom_any;

  assign rom_live = rom_hit & rom_map;

  // lowest index wins on overlap
  always_comb begin
    rom_oh  = '0;
    rom_any = 1'b0;
    for (int i = NUM_ROM - 1; i >= 0; i--) begin
      if (rom_live[i]) begin
        rom_oh    = '0;
        rom_oh[i] = 1'b1;
        rom_any   = 1'b1;
      end
    end
  end

  always_comb begin
    tgt = TGT_RAM;
    if (in_io && io_map) begin
      tgt = in_snd ? TGT_SND : TGT_IO;
    end else if (rw) begin
      if (in_io && chr_map) tgt = TGT_CHR;
      else if (rom_any)     tgt = TGT_ROM;
    end
  end
endmodule

// File: rtl/mem_decoder.sv
module mem_decoder
  import mdec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_ROM = 2,
  parameter logic [NUM_ROM*ADDR_W-1:0] ROM_BASE = {16'hE000, 16'hA000},
  parameter logic [NUM_ROM*ADDR_W-1:0] ROM_SIZE = {16'h2000, 16'h2000},
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'hD000,
  parameter logic [ADDR_W-1:0] IO_SIZE  = 16'h1000,
  parameter logic [ADDR_W-1:0] SND_BASE = 16'hD400,
  parameter logic [ADDR_W-1:0] SND_SIZE = 16'h0400
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_rw,
  input  logic               phi2,
  input  logic [NUM_ROM-1:0] rom_map,
  input  logic               io_map,
  input  logic               chr_map,
  output logic               ram_ce0_n,
  output logic               ram_ce1,
  output logic               ram_oe_n,
  output logic               ram_we_n,
  output logic [NUM_ROM-1:0] rom_sel,
  output logic               io_sel,
  output logic               snd_sel,
  output logic               chr_sel
);
  logic [NUM_ROM-1:0] rom_hit;
  logic [NUM_ROM-1:0] rom_oh;
  logic               in_io;
  logic               in_snd;
  tgt_e               tgt;

  for (genvar g = 0; g < NUM_ROM; g++) begin : g_rom
    mdec_region #(
      .ADDR_W(ADDR_W),
      .BASE  (ROM_BASE[g*ADDR_W +: ADDR_W]),
      .SIZE  (ROM_SIZE[g*ADDR_W +: ADDR_W])
    ) u_rgn (
      .addr(cpu_addr),
      .hit (rom_hit[g])
    );
  end

  mdec_region #(.ADDR_W(ADDR_W), .BASE(IO_BASE), .SIZE(IO_SIZE)) u_io (
    .addr(cpu_addr),
    .hit (in_io)
  );

  mdec_region #(.ADDR_W(ADDR_W), .BASE(SND_BASE), .SIZE(SND_SIZE)) u_snd (
    .addr(cpu_addr),
    .hit (in_snd)
  );

  mdec_route #(.NUM_ROM(NUM_ROM)) u_route (
    .rw     (cpu_rw),
    .in_io  (in_io),
    .in_snd (in_snd),
    .rom_hit(rom_hit),
    .rom_map(rom_map),
    .io_map (io_map),
    .chr_map(chr_map),
    .tgt    (tgt),
    .rom_oh (rom_oh)
  );

  logic to_ram;
  assign to_ram = (tgt == TGT_RAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ce0_n <= 1'b1;
      ram_ce1   <= 1'b0;
      ram_oe_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      rom_sel   <= '0;
      io_sel    <= 1'b0;
      snd_sel   <= 1'b0;
      chr_sel   <= 1'b0;
    end else begin
      ram_ce0_n <= !to_ram;
      ram_ce1   <= phi2;
      ram_oe_n  <= !(phi2 && cpu_rw && to_ram);
      ram_we_n  <= !(phi2 && !cpu_rw && to_ram);
      rom_sel   <= (phi2 && tgt == TGT_ROM) ? rom_oh : '0;
      io_sel    <= phi2 && (tgt == TGT_IO);
      snd_sel   <= phi2 && (tgt == TGT_SND);
      chr_sel   <= phi2 && (tgt == TGT_CHR);
    end
  end
endmodule

// File: rtl/mem_decoder_chk.sv
module mem_decoder_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_ROM = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               cpu_rw,
  input logic               phi2,
  input logic [NUM_ROM-1:0] rom_map,
  input logic               io_map,
  input logic               chr_map,
  input logic               ram_ce0_n,
  input logic               ram_ce1,
  input logic               ram_oe_n,
  input logic               ram_we_n,
  input logic [NUM_ROM-1:0] rom_sel,
  input logic               io_sel,
  input logic               snd_sel,
  input logic               chr_sel
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r11_one_source: assert property (@(posedge clk) disable iff (rst)
    $countones({rom_sel, io_sel, snd_sel, chr_sel, !ram_oe_n}) <= 1);

  a_r11_oe_we_apart: assert property (@(posedge clk) disable iff (rst)
    !(!ram_oe_n && !ram_we_n));

  a_r2_ce1_tracks_phi2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (ram_ce1 == $past(phi2)));

  a_r2_quiet_low: assert property (@(posedge clk) disable iff (rst)
    !ram_ce1 |-> (ram_oe_n && ram_we_n && rom_sel == '0 && !io_sel && !snd_sel && !chr_sel));

  a_r2_ram_access_enabled: assert property (@(posedge clk) disable iff (rst)
    (!ram_oe_n || !ram_we_n) |-> (!ram_ce0_n && ram_ce1));

  a_r4_write_no_rom: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!cpu_rw)) |-> (rom_sel == '0 && !chr_sel && ram_oe_n));

  a_r9_chr_hidden: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(io_map)) |-> !chr_sel);

  a_r6_io_hides_ram: assert property (@(posedge clk) disable iff (rst)
    (io_sel || snd_sel) |-> (ram_ce0_n && ram_we_n && ram_oe_n));
endmodule

bind mem_decoder mem_decoder_chk #(.ADDR_W(ADDR_W), .NUM_ROM(NUM_ROM)) u_chk (.*);

// File: tb/tb_mem_decoder.sv
module tb_mem_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] cpu_addr;
  logic          cpu_rw;
  logic          phi2;
  logic [NR-1:0] rom_map;
  logic          io_map;
  logic          chr_map;
  logic          ram_ce0_n, ram_ce1, ram_oe_n, ram_we_n;
  logic [NR-1:0] rom_sel;
  logic          io_sel, snd_sel, chr_sel;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_decoder dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .phi2(phi2),
    .rom_map(rom_map), .io_map(io_map), .chr_map(chr_map),
    .ram_ce0_n(ram_ce0_n), .ram_ce1(ram_ce1), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .rom_sel(rom_sel), .io_sel(io_sel), .snd_sel(snd_sel), .chr_sel(chr_sel)
  );

  // {ce0_n, ce1, oe_n, we_n, rom_sel[1:0], io, snd, chr}
  localparam logic [9:0] E_RESET   = 10'b1_0_1_1_00_000;
  localparam logic [9:0] E_RAM_RD  = 10'b0_1_0_1_00_000;
  localparam logic [9:0] E_RAM_WR  = 10'b0_1_1_0_00_000;
  localparam logic [9:0] E_ROM0_RD = 10'b1_1_1_1_01_000;
  localparam logic [9:0] E_ROM1_RD = 10'b1_1_1_1_10_000;
  localparam logic [9:0] E_IO      = 10'b1_1_1_1_00_100;
  localparam logic [9:0] E_SND     = 10'b1_1_1_1_00_010;
  localparam logic [9:0] E_CHR     = 10'b1_1_1_1_00_001;
  localparam logic [9:0] E_LOW_RAM = 10'b0_0_1_1_00_000;
  localparam logic [9:0] E_LOW_DEV = 10'b1_0_1_1_00_000;

  function automatic logic [9:0] observed();
    return {ram_ce0_n, ram_ce1, ram_oe_n, ram_we_n, rom_sel, io_sel, snd_sel, chr_sel};
  endfunction

  // drive on the falling edge, sample just after the next rising edge
  task automatic apply(input logic [AW-1:0] a, input logic rw, input logic p2,
                       input logic [NR-1:0] rm, input logic im, input logic cm);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; phi2 = p2; rom_map = rm; io_map = im; chr_map = cm;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [9:0] exp);
    n_vec++;
    if (observed() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (ce0_n ce1 oe_n we_n rom[1:0] io snd chr)",
               req, observed(), exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(16'h1000, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0);
    check("R1 reset values", E_RESET);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_phase_and_plain();
    apply(16'h1000, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0);
    check("R2 phi2 low, RAM decode but no enables", E_LOW_RAM);
    apply(16'h1000, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0);
    check("R12 plain RAM read", E_RAM_RD);
    apply(16'h2345, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0);
    check("R12 plain RAM write", E_RAM_WR);
    apply(16'hA100, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0);
    check("R2 phi2 low over mapped ROM", E_LOW_DEV);
  endtask

  task automatic t_rom();
    apply(16'hA123, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
    check("R3 overlay 0 read", E_ROM0_RD);
    apply(16'hE456, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
    check("R5 overlay 1 unmapped read from RAM", E_RAM_RD);
    apply(16'hFFFF, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0);
    check("R3 overlay 1 read at top", E_ROM1_RD);
    apply(16'hBFFF, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    check("R5 overlay 0 unmapped read from RAM", E_RAM_RD);
  endtask

  task automatic t_write_through();
    apply(16'hA010, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1);
    check("R4 write under overlay 0", E_RAM_WR);
    apply(16'hE000, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1);
    check("R4 write under overlay 1", E_RAM_WR);
  endtask

  task automatic t_io();
    apply(16'hD020, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    check("R6 I/O read", E_IO);
    apply(16'hD020, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
    check("R6 I/O write hides RAM", E_IO);
    apply(16'hD400, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    check("R7 sound window low edge", E_SND);
    apply(16'hD7FF, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
    check("R7 sound window high edge", E_SND);
    apply(16'hD800, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    check("R7 just above sound window", E_IO);
    apply(16'hD3FF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    check("R7 just below sound window", E_IO);
  endtask

  task automatic t_chr();
    apply(16'hD100, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R8 char ROM read", E_CHR);
    apply(16'hD100, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    check("R8 write under char ROM", E_RAM_WR);
    apply(16'hD100, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
    check("R9 char ROM hidden by I/O", E_IO);
    apply(16'hDFFF, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    check("R10 I/O range read as RAM", E_RAM_RD);
    apply(16'hD500, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    check("R10 I/O range write as RAM", E_RAM_WR);
  endtask

  task automatic t_exclusive();
    // R11: a one-hot/zero read source and never OE with WE, over a spread of cases
    for (int k = 0; k < 16; k++) begin
      apply({k[3:0], 12'h0F0}, k[0], 1'b1, 2'b11, k[1], k[2]);
      n_vec++;
      if ($countones({rom_sel, io_sel, snd_sel, chr_sel, !ram_oe_n}) > 1 ||
          (!ram_oe_n && !ram_we_n)) begin
        n_fail++;
        $display("FAIL R11 exclusive sources: got %b expected at most one source", observed());
      end
    end
  endtask

  initial begin
    cpu_addr = '0; cpu_rw = 1'b1; phi2 = 1'b0; rom_map = '0; io_map = 1'b0; chr_map = 1'b0;
    rst = 1'b1;
    t_reset();
    t_phase_and_plain();
    t_rom();
    t_write_through();
    t_io();
    t_chr();
    t_exclusive();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule